// File: doc/BRIEF.md
# Time-Slot-Zero Register Access Channel

This block carries register reads and writes inside time slot zero of a TDM multiplex, so a remote controller can reach a small register file without a parallel host bus. A frame strobe marks the first bit of time slot zero in each frame. The block shifts in the eight serial bits that follow, least significant bit first, and builds two-byte messages from the bytes it receives in consecutive frames.

A header byte has bit 7 clear. It holds a direction flag in bit 6, where 1 means read, and a six-bit register address in bits 5:0. A payload byte has bit 7 set and holds seven data bits in bits 6:0. A write message produces one write strobe on the register file port. A read message samples the addressed register. The reply goes out in the next two outgoing time-slot-zero windows. The serial output is enabled only while one of those reply bytes is being sent. At every other time it is disabled, which models a high-impedance pin.

Top module: `ts0_reg_channel`

## Requirements
- R1: The slot window covers the strobe cycle and the 7 cycles after it. Bit k of the received byte is the `sdi_i` value in window cycle k, so bit 0 is first on the wire. `sdi_i` has no effect outside the window.
- R2: A header with bit 7 = 0 and bit 6 = 0, followed in the next window by a payload with bit 7 = 1, produces exactly one `we_o` pulse. The pulse is one cycle long and lands in the cycle after the payload's last bit. It carries `waddr_o` = header bits 5:0 and `wdata_o` = payload bits 6:0.
- R3: A header with bit 6 = 1, followed by a payload, completes a read. A read never raises `we_o`.
- R4: After a completed read, the next window sends the byte {0,1,addr[5:0]} and the window after that sends {1,data[6:0]}. Both are sent LSB first with `sdo_oe_o` high for all 8 window cycles. The data is the `rdata_i` value for `raddr_o` = addr, sampled when the read completes.
- R5: A payload byte (bit 7 = 1) that has no header pending is discarded. It causes no write and no reply.
- R6: A header arriving while a payload is expected abandons the pending message. The new header starts a fresh message.
- R7: `sdo_oe_o` is low outside the window. It is also low during any window that carries no reply byte.
- R8: After reset, `sdo_oe_o` and `we_o` are low and no message is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fs_i | input | 1 | High in the cycle of bit 0 of time slot zero |
| sdi_i | input | 1 | Serial multiplex data in |
| sdo_o | output | 1 | Serial multiplex data out |
| sdo_oe_o | output | 1 | Output enable for `sdo_o` |
| we_o | output | 1 | Register file write strobe |
| waddr_o | output | 6 | Register file write address |
| wdata_o | output | 7 | Register file write data |
| raddr_o | output | 6 | Register file read address |
| rdata_i | input | 7 | Register file read data |

## Verification
The bench writes all 64 addresses with distinct data and then reads each one back. This exposes bit-order or address-slicing mistakes, which show up as data landing at the wrong address or a reply whose header does not echo the request. Stray payload bytes are sent in idle frames: a design that accepts orphan payloads would issue spurious writes. A header is replaced mid-message: a design that keeps the stale header would write to the abandoned address or send an unwanted reply. Random noise drives `sdi_i` outside the window, and every idle cycle checks that the output enable stays low. This catches a window that is too long or a reply that is sent in the wrong frames.

// File: rtl/ts0_pkg.sv
package ts0_pkg;
  localparam int SLOT_W = 8;
  localparam int IDX_W  = $clog2(SLOT_W);
  localparam int ADDR_W = SLOT_W - 2;
  localparam int DATA_W = SLOT_W - 1;
  localparam int FLAG_B = SLOT_W - 1;  // header/payload marker
  localparam int RW_B   = SLOT_W - 2;  // read request in header

  typedef enum logic [1:0] {TX_IDLE, TX_HDR, TX_DAT} tx_st_e;

  function automatic logic [SLOT_W-1:0] hdr_byte(input logic [ADDR_W-1:0] a);
    return {1'b0, 1'b1, a};
  endfunction

  function automatic logic [SLOT_W-1:0] dat_byte(input logic [DATA_W-1:0] d);
    return {1'b1, d};
  endfunction
endpackage

// File: rtl/ts0_win.sv
module ts0_win
  import ts0_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fs_i,
  output logic             win_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             last_o
);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(SLOT_W - 1);

  logic             busy;
  logic [IDX_W-1:0] cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (fs_i) begin
      busy <= 1'b1;
      cnt  <= IDX_W'(1);
    end else if (busy) begin
      cnt <= cnt + IDX_W'(1);
      if (cnt == IDX_LAST) busy <= 1'b0;
    end
  end

  assign win_o  = fs_i | busy;
  assign idx_o  = fs_i ? '0 : cnt;
  assign last_o = win_o && (idx_o == IDX_LAST);

  a_r1_win_closes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && !fs_i && cnt == IDX_LAST) |=> !busy);
endmodule

// File: rtl/ts0_rx.sv
module ts0_rx
  import ts0_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sdi_i,
  input  logic              win_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic              last_i,
  output logic              vld_o,
  output logic [SLOT_W-1:0] byte_o
);
  logic [SLOT_W-1:0] sh;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    sh <= '0;
    else if (win_i) sh[idx_i] <= sdi_i;
  end

  // last bit bypasses the register so the byte is usable at the final edge
  always_comb begin
    byte_o         = sh;
    byte_o[FLAG_B] = sdi_i;
  end

  assign vld_o = last_i;
endmodule

// File: rtl/ts0_msg.sv
module ts0_msg
  import ts0_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              vld_i,
  input  logic [SLOT_W-1:0] byte_i,
  output logic              we_o,
  output logic [ADDR_W-1:0] waddr_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic [ADDR_W-1:0] raddr_o,
  output logic              fire_o
);
  logic              pend;
  logic              p_rw;
  logic [ADDR_W-1:0] p_addr;
  logic              first, second;

  assign first  = vld_i && !byte_i[FLAG_B];
  assign second = vld_i &&  byte_i[FLAG_B] && pend;
  assign fire_o = second && p_rw;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend    <= 1'b0;
      p_rw    <= 1'b0;
      p_addr  <= '0;
      we_o    <= 1'b0;
      waddr_o <= '0;
      wdata_o <= '0;
    end else begin
      we_o <= 1'b0;
      if (first) begin
        pend   <= 1'b1;
        p_rw   <= byte_i[RW_B];
        p_addr <= byte_i[ADDR_W-1:0];
      end else if (second) begin
        pend <= 1'b0;
        if (!p_rw) begin
          we_o    <= 1'b1;
          waddr_o <= p_addr;
          wdata_o <= byte_i[DATA_W-1:0];
        end
      end
    end
  end

  assign raddr_o = p_addr;

  a_r5_we_needs_pend: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_o |-> $past(pend));
  a_r6_header_arms: assert property (@(posedge clk_i) disable iff (!rst_ni)
    first |=> (pend && p_addr == $past(byte_i[ADDR_W-1:0])));
endmodule

// File: rtl/ts0_tx.sv
module ts0_tx
  import ts0_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fire_i,
  input  logic              win_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic              last_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              sdo_o,
  output logic              oe_o
);
  tx_st_e            st;
  logic [ADDR_W-1:0] r_addr;
  logic [DATA_W-1:0] r_data;
  logic [SLOT_W-1:0] cur;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st     <= TX_IDLE;
      r_addr <= '0;
      r_data <= '0;
    end else if (fire_i) begin
      st     <= TX_HDR;
      r_addr <= rd_addr_i;
      r_data <= rd_data_i;
    end else if (last_i) begin
      case (st)
        TX_HDR:  st <= TX_DAT;
        default: st <= TX_IDLE;
      endcase
    end
  end

  assign cur   = (st == TX_HDR) ? hdr_byte(r_addr) : dat_byte(r_data);
  assign oe_o  = win_i && (st != TX_IDLE);
  assign sdo_o = oe_o && cur[idx_i];

  a_r4_dat_after_hdr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == TX_DAT) |-> ($past(st) != TX_IDLE));
endmodule

// File: rtl/ts0_reg_channel.sv
module ts0_reg_channel
  import ts0_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fs_i,
  input  logic              sdi_i,
  output logic              sdo_o,
  output logic              sdo_oe_o,
  output logic              we_o,
  output logic [ADDR_W-1:0] waddr_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic [ADDR_W-1:0] raddr_o,
  input  logic [DATA_W-1:0] rdata_i
);
  logic              win, last, vld, fire;
  logic [IDX_W-1:0]  idx;
  logic [SLOT_W-1:0] rx_byte;

  ts0_win u_win (
    .clk_i, .rst_ni, .fs_i,
    .win_o(win), .idx_o(idx), .last_o(last)
  );

  ts0_rx u_rx (
    .clk_i, .rst_ni, .sdi_i,
    .win_i(win), .idx_i(idx), .last_i(last),
    .vld_o(vld), .byte_o(rx_byte)
  );

  ts0_msg u_msg (
    .clk_i, .rst_ni,
    .vld_i(vld), .byte_i(rx_byte),
    .we_o, .waddr_o, .wdata_o, .raddr_o,
    .fire_o(fire)
  );

  ts0_tx u_tx (
    .clk_i, .rst_ni,
    .fire_i(fire), .win_i(win), .idx_i(idx), .last_i(last),
    .rd_addr_i(raddr_o), .rd_data_i(rdata_i),
    .sdo_o, .oe_o(sdo_oe_o)
  );

  a_r7_oe_in_win: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sdo_oe_o |-> win);
  a_r2_we_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_o |=> !we_o);
  a_r3_read_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire |=> !we_o);
endmodule

// File: tb/sim_ts0_reg_channel.sv
module sim_ts0_reg_channel;
  logic       clk = 1'b0, rst_n = 1'b0, fs = 1'b0, sdi = 1'b0;
  logic       sdo, oe, we;
  logic [5:0] waddr, raddr;
  logic [6:0] wdata, rdata;
  logic [6:0] mem [64];
  logic [6:0] exp_mem [64];
  int total = 0, bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  ts0_reg_channel u0 (
    .clk_i(clk), .rst_ni(rst_n), .fs_i(fs), .sdi_i(sdi),
    .sdo_o(sdo), .sdo_oe_o(oe), .we_o(we), .waddr_o(waddr), .wdata_o(wdata),
    .raddr_o(raddr), .rdata_i(rdata)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) for (int i = 0; i < 64; i++) mem[i] <= '0;
    else if (we) mem[waddr] <= wdata;
  end
  assign rdata = mem[raddr];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // one 32-cycle frame: 8 slot bits then 24 noise bits
  task automatic frame(input logic [7:0] b, output logic [7:0] got, output int oe_n,
                       output int stray, output int we_n, output logic [5:0] wa,
                       output logic [6:0] wd);
    got = '0; oe_n = 0; stray = 0; we_n = 0; wa = '0; wd = '0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); fs = (i == 0); sdi = b[i]; #1;
      if (oe) oe_n++;
      got[i] = sdo;
      if (we) begin we_n++; wa = waddr; wd = wdata; end
    end
    for (int i = 0; i < 24; i++) begin
      @(negedge clk); fs = 1'b0; sdi = 1'($urandom_range(0, 1)); #1;
      if (oe) stray++;
      if (we) begin we_n++; wa = waddr; wd = wdata; end
    end
  endtask

  task automatic do_write(input logic [5:0] a, input logic [6:0] d);
    logic [7:0] g; int on, st, wn; logic [5:0] wa; logic [6:0] wd;
    frame({2'b00, a}, g, on, st, wn, wa, wd);
    chk(wn == 0, "R2 header alone writes", wn, 0);
    chk(on == 0 && st == 0, "R7 oe without reply", on + st, 0);
    frame({1'b1, d}, g, on, st, wn, wa, wd);
    chk(wn == 1 && wa == a && wd == d, "R2 write addr/data",
        {wn[3:0], 2'b00, wa, 1'b0, wd}, {4'd1, 2'b00, a, 1'b0, d});
    exp_mem[a] = d;
  endtask

  task automatic do_read(input logic [5:0] a);
    logic [7:0] g; int on, st, wn; logic [5:0] wa; logic [6:0] wd;
    frame({2'b01, a}, g, on, st, wn, wa, wd);
    frame(8'hAA, g, on, st, wn, wa, wd);
    chk(wn == 0, "R3 read causes write", wn, 0);
    frame(8'hFF, g, on, st, wn, wa, wd);  // orphan payload, R5
    chk(on == 8 && st == 0 && g == {2'b01, a}, "R4 reply header",
        {on[7:0], g}, {8'd8, 2'b01, a});
    chk(wn == 0, "R5 orphan payload wrote", wn, 0);
    frame(8'hC3, g, on, st, wn, wa, wd);
    chk(on == 8 && st == 0 && g == {1'b1, exp_mem[a]}, "R4 reply data",
        {on[7:0], g}, {8'd8, 1'b1, exp_mem[a]});
    frame(8'hFF, g, on, st, wn, wa, wd);
    chk(on == 0 && st == 0 && wn == 0, "R7 oe after reply", on + st + wn, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] g; int on, st, wn; logic [5:0] wa; logic [6:0] wd;
    for (int i = 0; i < 64; i++) exp_mem[i] = '0;
    repeat (3) @(negedge clk);
    #1;
    chk(oe == 0 && we == 0, "R8 reset outputs", {oe, we}, 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (5) @(negedge clk);
    #1;
    chk(oe == 0 && we == 0, "R8 idle after reset", {oe, we}, 0);

    // R1 R2: every address, distinct data
    for (int a = 0; a < 64; a++) do_write(6'(a), 7'((a * 37 + 5) & 127));
    // R3 R4: read all back
    for (int a = 0; a < 64; a++) do_read(6'(a));

    // R5: orphan payloads
    frame(8'hD5, g, on, st, wn, wa, wd);
    chk(wn == 0, "R5 orphan write", wn, 0);
    frame(8'hFF, g, on, st, wn, wa, wd);
    chk(on == 0 && wn == 0, "R5 orphan reply", on + wn, 0);

    // R6: header replaced by header
    frame({2'b00, 6'd5}, g, on, st, wn, wa, wd);
    frame({2'b00, 6'd9}, g, on, st, wn, wa, wd);
    chk(wn == 0, "R6 replaced header wrote", wn, 0);
    frame({1'b1, 7'h11}, g, on, st, wn, wa, wd);
    chk(wn == 1 && wa == 6'd9 && wd == 7'h11, "R6 restart write", {wa, 1'b0, wd}, {6'd9, 1'b0, 7'h11});
    exp_mem[9] = 7'h11;

    // R6: read header abandoned by write header
    frame({2'b01, 6'd3}, g, on, st, wn, wa, wd);
    frame({2'b00, 6'd4}, g, on, st, wn, wa, wd);
    frame({1'b1, 7'h22}, g, on, st, wn, wa, wd);
    chk(wn == 1 && wa == 6'd4 && wd == 7'h22, "R6 write after dropped read", {wa, 1'b0, wd}, {6'd4, 1'b0, 7'h22});
    exp_mem[4] = 7'h22;
    frame(8'hFF, g, on, st, wn, wa, wd);
    chk(on == 0 && st == 0, "R6 dropped read replied", on + st, 0);

    do_read(6'd5);
    do_read(6'd9);
    do_read(6'd4);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule